// File: doc/BRIEF.md
# NCO Mixer With Quarter-Rate Option

This block is the mixing stage that sits in front of the decimation filter in one channel of a digital down-converter. It takes a stream of real 16-bit samples, each marked by a valid strobe. Each sample is multiplied by a complex rotation, and the block emits an I/Q pair. The rotation normally comes from a 32-bit phase accumulator. The tuning word sets the step, fNCO × 2^32 / Fs, and the top 10 phase bits address a quarter-wave sine table. A cheaper quarter-rate mode can replace the accumulator. It rotates by a quarter turn per sample, so the multipliers are only 0 and ±1.

A control bit that never clears itself governs the tuning word. The new word is taken, and the phase and quarter-rate sequence restart, only when this bit changes state. A phase-invert input turns the NCO rotation the other way. The quarter-rate path has its own invert input. In real mode the block does no mixing and the accumulator step is zero. A gain of 0, 3 or 6 dB, with saturation, makes up for the mixing loss.

Top module: `nco_mix_top`

## Requirements
- R1: After reset, iq_valid_o, i_o and q_o are 0. The stored tuning word and the phase are 0. The stored copy of reload_tgl_i is 0.
- R2: iq_valid_o is high exactly two clock edges after an edge at which smp_valid_i was high. While iq_valid_o is low, i_o and q_o hold their values.
- R3: In NCO mode let p = phase[31:22] and θ = 2π(p+0.5)/1024. The outputs are i = floor(x·C/2^15) and q = floor(−x·S/2^15), where C and S are cos θ and sin θ scaled by 32767 and rounded. Values are two's complement. Each accepted sample is mixed with the current phase, and the phase then advances by the stored tuning word.
- R4: The stored tuning word is loaded, and the phase and quarter-rate step are cleared, only at an edge where reload_tgl_i differs from its previous value. Either direction of change counts. A change of tune_word_i alone has no effect.
- R5: With ph_inv_i high, p is replaced by its ones complement, which mixes with −θ.
- R6: With fs4_en_i high and real_mode_i low, step k (0..3) runs through I multipliers 1, 0, −1, 0 and Q multipliers 0, −1, 0, 1. The step starts at 0 and advances once per accepted sample.
- R7: With fs4_inv_i high in quarter-rate mode, the Q multiplier sequence becomes 0, 1, 0, −1.
- R8: With real_mode_i high, i = x and q = 0 regardless of fs4_en_i. The phase does not advance, so NCO mixing later resumes from the held phase.
- R9: gain_sel_i 00 passes the value through. 01 gives floor(v·181/128). 10 gives 2v. 11 acts as 00. The gain is applied to both I and Q.
- R10: Every result saturates to the range −32768..32767. This includes negating −32768 in quarter-rate mode, which gives 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_i | input | 16 | Real input sample, two's complement |
| tune_word_i | input | 32 | NCO tuning word |
| reload_tgl_i | input | 1 | Level bit; a change loads the word and clears the phase |
| ph_inv_i | input | 1 | Reverse the NCO rotation |
| fs4_en_i | input | 1 | Select quarter-rate rotation |
| fs4_inv_i | input | 1 | Reverse the quarter-rate rotation |
| real_mode_i | input | 1 | No mixing, zero phase step |
| gain_sel_i | input | 2 | Post-mixer gain code |
| iq_valid_o | output | 1 | Output pair strobe |
| i_o | output | 16 | In-phase output |
| q_o | output | 16 | Quadrature output |

## Verification
The bench changes tune_word_i without toggling the reload bit. A design that loads the word on any write would shift the phase, and the mixed values would then differ from the model. It toggles the reload bit in both directions, because a design that acts only on a rising edge would keep the old phase after a falling one. It drives −32768 into the quarter-rate negation and full-scale values into the 3 dB and 6 dB gains. Missing saturation would show up there as a wrapped sign. It also switches from real mode back to NCO mode. A design that kept stepping the phase in real mode would then resume with the wrong rotation.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  typedef enum logic [1:0] {
    GAIN_0DB = 2'b00,
    GAIN_3DB = 2'b01,
    GAIN_6DB = 2'b10,
    GAIN_RSV = 2'b11
  } gain_e;

  localparam int G3_NUM   = 181;  // 181/128 ~ sqrt(2)
  localparam int G3_SHIFT = 7;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [ACC_W-1:0] tune_word_i,
  input  logic             reload_tgl_i,
  input  logic             hold_i,
  output logic [ACC_W-1:0] phase_o,
  output logic [1:0]       fs4_k_o
);
  logic             tgl_q;
  logic [ACC_W-1:0] word_q;
  logic [ACC_W-1:0] phase_q;
  logic [1:0]       k_q;
  logic             reload;
  logic [ACC_W-1:0] inc;

  assign reload = reload_tgl_i ^ tgl_q;
  assign inc    = hold_i ? '0 : word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q   <= 1'b0;
      word_q  <= '0;
      phase_q <= '0;
      k_q     <= '0;
    end else begin
      tgl_q <= reload_tgl_i;
      if (reload) begin
        word_q  <= tune_word_i;
        phase_q <= '0;
        k_q     <= '0;
      end else if (step_i) begin
        phase_q <= phase_q + inc;
        k_q     <= k_q + 2'd1;
      end
    end
  end

  assign phase_o = phase_q;
  assign fs4_k_o = k_q;
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int AMP_W = 16,
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int AW      = IDX_W - 2;
  localparam int QTR     = 1 << AW;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
  localparam logic [IDX_W-1:0] QTR_IDX = IDX_W'(QTR);

  function automatic logic [QTR*AMP_W-1:0] build_lut();
    logic [QTR*AMP_W-1:0] t;
    real x, x2, s, v;
    logic [31:0] r;
    t = '0;
    for (int k = 0; k < QTR; k++) begin
      x  = 2.0 * 3.14159265358979 * (real'(k) + 0.5) / real'(4 * QTR);
      x2 = x * x;
      s  = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0 * (1.0 - x2 / 72.0))));
      v  = s * real'(AMP_MAX) + 0.5;
      r  = 32'($rtoi(v));
      t[k*AMP_W +: AMP_W] = r[AMP_W-1:0];
    end
    return t;
  endfunction

  localparam logic [QTR*AMP_W-1:0] LUT = build_lut();

  function automatic logic signed [AMP_W-1:0] rd(input logic [IDX_W-1:0] idx);
    logic [AW-1:0]           a;
    logic signed [AMP_W-1:0] mag;
    a   = idx[AW] ? ~idx[AW-1:0] : idx[AW-1:0];
    mag = LUT[int'(a)*AMP_W +: AMP_W];
    return idx[IDX_W-1] ? -mag : mag;
  endfunction

  assign sin_o = rd(idx_i);
  assign cos_o = rd(idx_i + QTR_IDX);
endmodule

// File: rtl/nco_gain_sat.sv
module nco_gain_sat
  import nco_mix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] d_i,
  input  gain_e               sel_i,
  output logic signed [W-1:0] q_o
);
  localparam int EW = W + 9;
  localparam logic signed [EW-1:0] K3   = EW'(G3_NUM);
  localparam logic signed [EW-1:0] MAXV = EW'((1 << (W - 1)) - 1);
  localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

  logic signed [EW-1:0] dx;
  logic signed [EW-1:0] wide;

  always_comb begin
    dx = EW'(d_i);
    unique case (sel_i)
      GAIN_3DB: wide = (dx * K3) >>> G3_SHIFT;
      GAIN_6DB: wide = dx <<< 1;
      default:  wide = dx;
    endcase
    if (wide > MAXV)      q_o = MAXV[W-1:0];
    else if (wide < MINV) q_o = MINV[W-1:0];
    else                  q_o = wide[W-1:0];
  end
endmodule

// File: rtl/nco_mix_top.sv
module nco_mix_top
  import nco_mix_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int ACC_W = 32,
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [ACC_W-1:0] tune_word_i,
  input  logic             reload_tgl_i,
  input  logic             ph_inv_i,
  input  logic             fs4_en_i,
  input  logic             fs4_inv_i,
  input  logic             real_mode_i,
  input  logic [1:0]       gain_sel_i,
  output logic             iq_valid_o,
  output logic [SMP_W-1:0] i_o,
  output logic [SMP_W-1:0] q_o
);
  localparam int PW = 2 * SMP_W;
  localparam logic signed [SMP_W-1:0] SMAX = SMP_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [SMP_W-1:0] SMIN = ~SMAX;

  logic [ACC_W-1:0] phase;
  logic [1:0]       fs4_k;
  logic [IDX_W-1:0] idx;
  logic signed [SMP_W-1:0] cos_w, sin_w, nsin_w;
  logic signed [SMP_W-1:0] x, neg_x;
  logic signed [PW-1:0]    prod_i, prod_q;
  logic signed [SMP_W-1:0] nco_i, nco_q, f4_i, f4_q, mix_i, mix_q;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (smp_valid_i),
    .tune_word_i  (tune_word_i),
    .reload_tgl_i (reload_tgl_i),
    .hold_i       (real_mode_i),
    .phase_o      (phase),
    .fs4_k_o      (fs4_k)
  );

  // ones complement of the index mirrors the half-step-offset angle to -theta
  assign idx = ph_inv_i ? ~phase[ACC_W-1 -: IDX_W] : phase[ACC_W-1 -: IDX_W];

  nco_sincos #(.AMP_W(SMP_W), .IDX_W(IDX_W)) u_lut (
    .idx_i (idx),
    .cos_o (cos_w),
    .sin_o (sin_w)
  );

  assign x      = signed'(smp_i);
  assign nsin_w = -sin_w;
  assign prod_i = PW'(x) * PW'(cos_w);
  assign prod_q = PW'(x) * PW'(nsin_w);
  assign nco_i  = prod_i[SMP_W-1 +: SMP_W];
  assign nco_q  = prod_q[SMP_W-1 +: SMP_W];
  assign neg_x  = (x == SMIN) ? SMAX : -x;

  always_comb begin
    f4_i = '0;
    f4_q = '0;
    unique case (fs4_k)
      2'd0: f4_i = x;
      2'd1: f4_q = fs4_inv_i ? x : neg_x;
      2'd2: f4_i = neg_x;
      default: f4_q = fs4_inv_i ? neg_x : x;
    endcase
    if (real_mode_i) begin
      mix_i = x;
      mix_q = '0;
    end else if (fs4_en_i) begin
      mix_i = f4_i;
      mix_q = f4_q;
    end else begin
      mix_i = nco_i;
      mix_q = nco_q;
    end
  end

  logic                    s1_vld;
  logic signed [SMP_W-1:0] s1_lane [2];
  logic signed [SMP_W-1:0] g_lane  [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld     <= 1'b0;
      s1_lane[0] <= '0;
      s1_lane[1] <= '0;
    end else begin
      s1_vld <= smp_valid_i;
      if (smp_valid_i) begin
        s1_lane[0] <= mix_i;
        s1_lane[1] <= mix_q;
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_gain
    nco_gain_sat #(.W(SMP_W)) u_gain (
      .d_i   (s1_lane[l]),
      .sel_i (gain_e'(gain_sel_i)),
      .q_o   (g_lane[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iq_valid_o <= 1'b0;
      i_o        <= '0;
      q_o        <= '0;
    end else begin
      iq_valid_o <= s1_vld;
      if (s1_vld) begin
        i_o <= g_lane[0];
        q_o <= g_lane[1];
      end
    end
  end
endmodule

// File: rtl/nco_mix_chk.sv
module nco_mix_chk #(
  parameter int SMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic [SMP_W-1:0] smp_i,
  input logic             real_mode_i,
  input logic             fs4_en_i,
  input logic [1:0]       gain_sel_i,
  input logic             iq_valid_o,
  input logic [SMP_W-1:0] i_o,
  input logic [SMP_W-1:0] q_o
);
  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end
  assign warm = age >= 2'd2;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (iq_valid_o == $past(smp_valid_i, 2))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !iq_valid_o) |-> ($stable(i_o) && $stable(q_o))); // R2

  AST_REAL_Q_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && iq_valid_o && $past(real_mode_i, 2)) |-> (q_o == '0)); // R8

  AST_FS4_ONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && iq_valid_o && $past(fs4_en_i && !real_mode_i, 2)) |-> (i_o == '0 || q_o == '0)); // R6

  AST_PASS_0DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && iq_valid_o && $past(real_mode_i, 2) && $past(gain_sel_i == 2'b00, 1))
      |-> (i_o == $past(smp_i, 2))); // R9
endmodule

bind nco_mix_top nco_mix_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_i       (smp_i),
  .real_mode_i (real_mode_i),
  .fs4_en_i    (fs4_en_i),
  .gain_sel_i  (gain_sel_i),
  .iq_valid_o  (iq_valid_o),
  .i_o         (i_o),
  .q_o         (q_o)
);

// File: tb/sim_nco_mix_top.sv
module sim_nco_mix_top;
  localparam int CLK_P = 10;
  localparam real PI = 3.14159265358979;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic [31:0] tune_word_i = '0;
  logic        reload_tgl_i = 1'b0;
  logic        ph_inv_i = 1'b0;
  logic        fs4_en_i = 1'b0;
  logic        fs4_inv_i = 1'b0;
  logic        real_mode_i = 1'b0;
  logic [1:0]  gain_sel_i = 2'b00;
  logic        iq_valid_o;
  logic [15:0] i_o, q_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] b_phase = '0;
  logic [31:0] b_word = '0;
  logic [1:0]  b_k = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  nco_mix_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .tune_word_i(tune_word_i), .reload_tgl_i(reload_tgl_i), .ph_inv_i(ph_inv_i),
    .fs4_en_i(fs4_en_i), .fs4_inv_i(fs4_inv_i), .real_mode_i(real_mode_i),
    .gain_sel_i(gain_sel_i), .iq_valid_o(iq_valid_o), .i_o(i_o), .q_o(q_o)
  );

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int gain(input int v, input logic [1:0] sel);
    case (sel)
      2'b01: return sat16((v * 181) >>> 7);
      2'b10: return sat16(v * 2);
      default: return v;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input string req);
    int ei, eq, tol, c, s, negx;
    logic [9:0] idx;
    if (real_mode_i) begin
      ei = x; eq = 0; tol = 0;
    end else if (fs4_en_i) begin
      negx = (x == -32768) ? 32767 : -x;
      ei = 0; eq = 0; tol = 0;
      case (b_k)
        2'd0: ei = x;
        2'd1: eq = fs4_inv_i ? x : negx;
        2'd2: ei = negx;
        default: eq = fs4_inv_i ? negx : x;
      endcase
    end else begin
      idx = b_phase[31:22];
      if (ph_inv_i) idx = ~idx;
      c = rnd(32767.0 * $cos(2.0 * PI * (real'(idx) + 0.5) / 1024.0));
      s = rnd(32767.0 * $sin(2.0 * PI * (real'(idx) + 0.5) / 1024.0));
      ei = int'((longint'(x) * longint'(c)) >>> 15);
      eq = int'((longint'(x) * longint'(-s)) >>> 15);
      tol = 3;
    end
    ei = gain(ei, gain_sel_i);
    eq = gain(eq, gain_sel_i);
    @(negedge clk_i);
    smp_valid_i = 1'b1;
    smp_i = x[15:0];
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    chk("R2 valid low after one edge", int'(iq_valid_o), 0, 0);
    @(negedge clk_i);
    chk("R2 valid after two edges", int'(iq_valid_o), 1, 0);
    chk({req, " I"}, int'($signed(i_o)), ei, tol);
    chk({req, " Q"}, int'($signed(q_o)), eq, tol);
    if (!real_mode_i) b_phase = b_phase + b_word;
    b_k = b_k + 2'd1;
  endtask

  task automatic reload(input logic [31:0] w);
    @(negedge clk_i);
    tune_word_i = w;
    reload_tgl_i = ~reload_tgl_i;
    @(negedge clk_i);
    b_word = w; b_phase = '0; b_k = '0;
  endtask

  task automatic set_mode(input int m);
    ph_inv_i = (m == 1);
    fs4_en_i = (m == 2) || (m == 3);
    fs4_inv_i = (m == 3);
    real_mode_i = (m == 4);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd4711);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", int'(iq_valid_o), 0, 0);
    chk("R1 i", int'(i_o), 0, 0);
    chk("R1 q", int'(q_o), 0, 0);
    // R1: zero word, zero phase: repeated samples see angle index 0
    send(20000, "R1 phase zero");
    send(-12345, "R1 phase held");

    // R3 basic NCO
    reload(32'h0123_4567);
    for (int n = 0; n < 8; n++) send(int'($signed(16'($urandom))), "R3 nco");
    // R4 word change without toggle ignored
    tune_word_i = 32'h4000_0000;
    repeat (3) @(negedge clk_i);
    for (int n = 0; n < 4; n++) send(30000, "R4 no toggle");
    // R4 toggle back to 0 reloads
    reload(32'h2000_0000);
    for (int n = 0; n < 4; n++) send(-30000, "R4 falling toggle");
    // R5 inversion
    set_mode(1);
    for (int n = 0; n < 6; n++) send(25000, "R5 inverted");
    // R6 / R7 / R10
    set_mode(2);
    reload(32'h1111_1111);
    send(-32768, "R6 fs4 k0");
    send(-32768, "R6 fs4 k1 R10");
    send(-32768, "R6 fs4 k2 R10");
    send(-32768, "R6 fs4 k3");
    set_mode(3);
    for (int n = 0; n < 4; n++) send(12000, "R7 fs4 inverted");
    // R8 real mode, phase hold then resume
    set_mode(4);
    send(-32768, "R8 real");
    send(777, "R8 real");
    set_mode(2);
    send(500, "R8 fs4 ignored in real check resume");
    set_mode(4); fs4_en_i = 1'b1;
    send(1234, "R8 fs4 ignored");
    set_mode(0);
    send(31000, "R8 resume phase");
    // R9 / R10 gains
    set_mode(4);
    gain_sel_i = 2'b10;
    send(32767, "R10 6dB max");
    send(-32768, "R10 6dB min");
    send(1000, "R9 6dB");
    gain_sel_i = 2'b01;
    send(30000, "R10 3dB sat");
    send(-1001, "R9 3dB");
    gain_sel_i = 2'b11;
    send(-4321, "R9 code 11");
    set_mode(0);
    gain_sel_i = 2'b01;
    send(20000, "R9 3dB nco");

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 15) == 0) reload($urandom);
      set_mode($urandom_range(0, 4));
      gain_sel_i = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 7))
        0: send(-32768, "R10 random extreme");
        1: send(32767, "R10 random extreme");
        default: send(int'($signed(16'($urandom))), "R3 random");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule